// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog counter that firmware must refresh, and a refresh counts only inside a window at the end of each period. Firmware refreshes it by writing a fixed key to a trigger register. A refresh that comes too early, a refresh with the wrong key, or a period that runs out with no refresh each count as a failure. A failure raises one of two requests, a non-maskable interrupt or a reset, and then the counter freezes until the next reset. An optional early-warning pulse marks the point where three quarters of the period have passed.

A 7-bit mode value controls the block. It sets the period, the early warning, the error response and the size of the open window. Firmware may write this value once between reset and the first refresh. The written value takes effect at the next valid refresh. Any later write that changes the value is a failure. A later write of the same value is harmless. Time is counted in base ticks, which here are clock cycles. `BASE_TICKS` is the length of the shortest period.

Top module: `wwdt_top`

## Requirements
- R1: After reset the mode register reads 0x7F at address 0, and all three request outputs are low.
- R2: Bit 7 of a mode write is ignored, and bit 7 always reads back as 0.
- R3: The first mode write before any valid trigger stores its value. After that, a mode write whose low 7 bits equal the current read value causes no error, and any other mode write is an error and leaves the register unchanged.
- R4: The stored mode only governs the counter from the next valid trigger onward. Until then, the reset configuration applies: period code 7, warning on, reset response, full window.
- R5: The period is BASE_TICKS shifted left by mode bits [6:4]. If P cycles pass after a valid trigger with no further valid trigger, an error pulse appears P cycles after that trigger.
- R6: Mode bits [1:0] = w open the last (w+1)/4 of the period. A key write while the count is below P*(3-w)/4 is an error. A key write at that count or later is accepted and restarts the count from zero.
- R7: A trigger is a write of 0xAC to address 1. A write of any other value to address 1 is an error.
- R8: When mode bit 3 is 1, `warn_irq_o` pulses for one cycle 3P/4 cycles after a valid trigger. When bit 3 is 0, it stays low.
- R9: Mode bit 2 selects the error line: 0 gives a one-cycle pulse on `nmi_req_o`, 1 gives a one-cycle pulse on `reset_req_o`. An error found in the same cycle as a write appears in the following output sample.
- R10: After an error, the counter stops. Trigger writes and mode writes then have no effect, and no further pulses appear until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register address: 0 mode, 1 trigger |
| we | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data for `addr` |
| warn_irq_o | output | 1 | Early-warning pulse |
| nmi_req_o | output | 1 | Non-maskable error request pulse |
| reset_req_o | output | 1 | Reset request pulse |

## Verification
The hardest cases to reach are the window edges. The bench must land a key write exactly one count before the window opens, and again exactly at the moment it opens, and this has to be done under a mode that has only just taken effect. For each combination of period code 0 to 3, warning enable, error response and window size, the bench works out the opening count arithmetically. It then waits that many cycles after a refresh before writing the key. Each combination runs from a fresh reset, so the write-once rule never blocks the sweep. The frozen state after an error is checked with writes that would otherwise have caused a pulse.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;
  localparam int          ADDR_W   = 2;
  localparam logic [1:0]  A_MODE   = 2'd0;
  localparam logic [1:0]  A_TRIG   = 2'd1;
  localparam logic [7:0]  TRIG_KEY = 8'hAC;

  typedef struct packed {
    logic [2:0] ovf;   // period code
    logic       wie;   // early warning enable
    logic       erm;   // 0: nmi, 1: reset request
    logic [1:0] ws;    // window size code
  } mode_t;

  localparam mode_t MODE_RST = 7'h7F;
  localparam int    NSRC     = 3;
endpackage

// File: rtl/wwdt_mode.sv
module wwdt_mode
  import wwdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic [6:0] wdata,
  input  logic       trig_ok,
  output mode_t      mode_rd,
  output mode_t      active,
  output logic       wr_err
);
  mode_t mode_q, act_q;
  logic  locked_q;

  assign mode_rd = mode_q;
  assign active  = act_q;
  assign wr_err  = wr && locked_q && (mode_t'(wdata) != mode_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MODE_RST;
      act_q    <= MODE_RST;
      locked_q <= 1'b0;
    end else begin
      if (wr && !locked_q) begin
        mode_q   <= mode_t'(wdata);
        locked_q <= 1'b1;
      end
      if (trig_ok) begin
        act_q    <= mode_q;
        locked_q <= 1'b1;
      end
    end
  end

  // R3: once locked, stored mode never changes
  p_locked_stable_r3: assert property (@(posedge clk) disable iff (rst)
    locked_q |=> $stable(mode_q));
  // R4: active configuration only moves on an accepted trigger
  p_active_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !trig_ok |=> $stable(act_q));
endmodule

// File: rtl/wwdt_count.sv
module wwdt_count
  import wwdt_pkg::*;
#(
  parameter int BASE_TICKS = 2048
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  run,
  input  mode_t cfg,
  input  logic  trig_wr,
  input  logic  key_ok,
  output logic  trig_ok,
  output logic  trig_err,
  output logic  ovf_err,
  output logic  warn_q
);
  localparam int CW = $clog2(BASE_TICKS) + 8;

  logic [CW-1:0] cnt, period, quarter, open_start, warn_pt, cnt_nxt;
  logic          win_open, last;

  assign period  = CW'(BASE_TICKS) << cfg.ovf;
  assign quarter = period >> 2;
  assign warn_pt = quarter + (quarter << 1);

  always_comb begin
    case (cfg.ws)
      2'd0:    open_start = warn_pt;
      2'd1:    open_start = quarter << 1;
      2'd2:    open_start = quarter;
      default: open_start = '0;
    endcase
  end

  assign win_open = cnt >= open_start;
  assign last     = cnt == period - 1'b1;
  assign cnt_nxt  = cnt + 1'b1;
  assign trig_ok  = run && trig_wr && key_ok && win_open;
  assign trig_err = run && trig_wr && !(key_ok && win_open);
  assign ovf_err  = run && last && !trig_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      warn_q <= 1'b0;
    end else begin
      warn_q <= run && !trig_ok && cfg.wie && (cnt_nxt == warn_pt);
      if (trig_ok)
        cnt <= '0;
      else if (run && !last)
        cnt <= cnt_nxt;
    end
  end

  // R5: count stays inside the selected period
  p_in_period_r5: assert property (@(posedge clk) disable iff (rst)
    cnt < period);
  // R10: a stopped counter holds its value
  p_halt_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(cnt));
  // R8: warning only when enabled
  p_warn_en_r8: assert property (@(posedge clk) disable iff (rst)
    warn_q |-> cfg.wie);
endmodule

// File: rtl/wwdt_err.sv
module wwdt_err
  import wwdt_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src,
  input  logic            erm,
  output logic            nmi_q,
  output logic            rst_q,
  output logic            halted
);
  logic fire;

  assign fire = (|src) && !halted;

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_q  <= 1'b0;
      rst_q  <= 1'b0;
      halted <= 1'b0;
    end else begin
      nmi_q <= fire && !erm;
      rst_q <= fire && erm;
      if (fire) halted <= 1'b1;
    end
  end

  // R9: one request line at a time, each a single-cycle pulse
  p_one_line_r9: assert property (@(posedge clk) disable iff (rst)
    !(nmi_q && rst_q));
  p_pulse_nmi_r9: assert property (@(posedge clk) disable iff (rst)
    nmi_q |=> !nmi_q);
  p_pulse_rst_r9: assert property (@(posedge clk) disable iff (rst)
    rst_q |=> !rst_q);
  // R10: stopped state is permanent until reset
  p_halt_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);
endmodule

// File: rtl/wwdt_top.sv
module wwdt_top
  import wwdt_pkg::*;
#(
  parameter int BASE_TICKS = 2048
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              warn_irq_o,
  output logic              nmi_req_o,
  output logic              reset_req_o
);
  mode_t           mode_rd, active;
  logic            halted, mode_wr, trig_wr, key_ok;
  logic            trig_ok, trig_err, ovf_err, wr_err;
  logic [NSRC-1:0] src;
  logic [7:0]      rdata_q;

  assign mode_wr = we && (addr == A_MODE) && !halted;
  assign trig_wr = we && (addr == A_TRIG);
  assign key_ok  = wdata == TRIG_KEY;
  assign src     = {ovf_err, trig_err, wr_err};

  wwdt_mode u_mode (
    .clk(clk), .rst(rst), .wr(mode_wr), .wdata(wdata[6:0]),
    .trig_ok(trig_ok), .mode_rd(mode_rd), .active(active), .wr_err(wr_err)
  );

  wwdt_count #(.BASE_TICKS(BASE_TICKS)) u_count (
    .clk(clk), .rst(rst), .run(!halted), .cfg(active),
    .trig_wr(trig_wr), .key_ok(key_ok), .trig_ok(trig_ok),
    .trig_err(trig_err), .ovf_err(ovf_err), .warn_q(warn_irq_o)
  );

  wwdt_err u_err (
    .clk(clk), .rst(rst), .src(src), .erm(active.erm),
    .nmi_q(nmi_req_o), .rst_q(reset_req_o), .halted(halted)
  );

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= 8'h00;
    else     rdata_q <= (addr == A_MODE) ? {1'b0, mode_rd} : 8'h00;
  end
  assign rdata = rdata_q;

  // R2: top bit of read data is always clear
  p_bit7_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !rdata_q[7]);
  // R10: no warning after the counter has stopped
  p_no_warn_halt_r10: assert property (@(posedge clk) disable iff (rst)
    halted |=> !warn_irq_o);
endmodule

// File: tb/sim_wwdt_top.sv
module sim_wwdt_top;
  import wwdt_pkg::*;
  localparam int BT = 8;

  logic       clk = 1'b0, rst = 1'b1, we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       warn, nmi, rrq;
  int         n_tests = 0, n_fail = 0, cyc = 0;
  int         fi, ni, fn, nn, fr, nr;

  always #2.5 clk = ~clk;

  wwdt_top #(.BASE_TICKS(BT)) u0 (
    .clk(clk), .rst(rst), .addr(addr), .we(we), .wdata(wdata), .rdata(rdata),
    .warn_irq_o(warn), .nmi_req_o(nmi), .reset_req_o(rrq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run exceeded %0d cycles (expected 150000)", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; we = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic trig();
    bus_wr(A_TRIG, TRIG_KEY);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rd_mode(output logic [7:0] v);
    addr = A_MODE; we = 1'b0;
    @(negedge clk);
    v = rdata;
  endtask

  // sample c = 0..n after the last write edge
  task automatic measure(input int n);
    fi = -1; fn = -1; fr = -1; ni = 0; nn = 0; nr = 0;
    for (int c = 0; c <= n; c++) begin
      if (warn) begin ni++; if (fi < 0) fi = c; end
      if (nmi)  begin nn++; if (fn < 0) fn = c; end
      if (rrq)  begin nr++; if (fr < 0) fr = c; end
      @(negedge clk);
    end
  endtask

  initial begin
    logic [7:0] v;
    do_reset();
    // R1 reset state
    check(!warn && !nmi && !rrq, "R1 outputs low", {warn, nmi, rrq}, 0);
    rd_mode(v);
    check(v == 8'h7F, "R1 mode reset", v, 8'h7F);

    // R2 bit 7 ignored
    bus_wr(A_MODE, 8'h8B);
    rd_mode(v);
    check(v == 8'h0B, "R2 bit7 ignored", v, 8'h0B);

    // R3 before start: equal rewrite ok, different rewrite -> reset line (reset config)
    do_reset();
    bus_wr(A_MODE, 8'h30);
    bus_wr(A_MODE, 8'hB0);
    measure(2);
    check(nn + nr == 0, "R3 equal rewrite no error", nn + nr, 0);
    bus_wr(A_MODE, 8'h31);
    measure(2);
    check(fr == 0 && nr == 1 && nn == 0, "R3 changed rewrite error", fr, 0);
    rd_mode(v);
    check(v == 8'h30, "R3 value kept", v, 8'h30);

    // R3 after start
    do_reset();
    bus_wr(A_MODE, 8'h0F);
    trig();
    bus_wr(A_MODE, 8'h8F);
    measure(1);
    check(nn + nr == 0, "R3 equal write after start", nn + nr, 0);
    bus_wr(A_MODE, 8'h0E);
    measure(1);
    check(fr == 0 && nr == 1, "R3 changed write after start", fr, 0);

    // R4 stored mode not active before trigger
    do_reset();
    bus_wr(A_MODE, 8'h03);
    measure(30);
    check(nn + nr == 0, "R4 old period before trigger", nn + nr, 0);
    trig();
    measure(12);
    check(fn == BT && nn == 1 && nr == 0, "R4 new period after trigger", fn, BT);

    // R7 wrong key
    do_reset();
    bus_wr(A_MODE, 8'h03);
    trig();
    bus_wr(A_TRIG, 8'h55);
    measure(2);
    check(fn == 0 && nn == 1, "R7 bad key error", fn, 0);

    // R10 stopped after error
    do_reset();
    bus_wr(A_MODE, 8'h00);
    trig();
    measure(BT + 2);
    check(fn == BT && nn == 1, "R10 overflow before halt", fn, BT);
    trig();
    bus_wr(A_TRIG, 8'h55);
    bus_wr(A_MODE, 8'h55);
    measure(5 * BT);
    check(nn + nr + ni == 0, "R10 no pulses after halt", nn + nr + ni, 0);
    rd_mode(v);
    check(v == 8'h00, "R10 mode unchanged", v, 0);

    // Sweep: period, warning, response, window
    for (int ovf = 0; ovf < 4; ovf++)
      for (int wie = 0; wie < 2; wie++)
        for (int erm = 0; erm < 2; erm++)
          for (int ws = 0; ws < 4; ws++) begin
            automatic int p = BT << ovf;
            automatic int q = p / 4;
            automatic int os = q * (3 - ws);
            automatic logic [6:0] m = {ovf[2:0], wie[0], erm[0], ws[1:0]};
            if (ws < 3) begin
              do_reset();
              bus_wr(A_MODE, {ws[0], m});
              trig();
              idle(os - 1);
              trig();
              measure(2);
              if (erm == 1)
                check(fr == 0 && nr == 1 && nn == 0, "R6 early trigger reset line", fr, 0);
              else
                check(fn == 0 && nn == 1 && nr == 0, "R6 early trigger nmi line", fn, 0);
            end
            do_reset();
            bus_wr(A_MODE, {ws[1], m});
            rd_mode(v);
            check(v == {1'b0, m}, "R2 sweep readback", v, {1'b0, m});
            trig();
            idle(os);
            trig();
            measure(p + 6);
            if (erm == 1)
              check(fr == p && nr == 1 && nn == 0, "R5 overflow reset line (R9)", fr, p);
            else
              check(fn == p && nn == 1 && nr == 0, "R5 overflow nmi line (R9)", fn, p);
            if (wie == 1)
              check(fi == 3 * q && ni == 1, "R8 warning at 75%", fi, 3 * q);
            else
              check(ni == 0, "R8 warning suppressed", ni, 0);
          end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule